// File: doc/BRIEF.md
# Charge-Pump Switch-Segment Controller

This block is the digital sequencer of a switched-capacitor step-down converter. It drives four power switches, each built from three segments (a first quarter, a second quarter and a half), through two non-overlapping phases separated by dead time. A mode-select comparator picks between halving operation (2:1) and pass-through operation (1:1). Regulation works by skipping pulses: while the output sits above its upper limit nothing switches. When the output falls to its lower limit, switching restarts on the smallest segment. Wider segments are added when the output stays slow to recover.

The comparators, reference, soft-start ramp and power stage are outside the block; each one reaches it as a single bit. The outputs are per-segment gate enables.

Top module: `cp_seg_ctrl`

## Requirements
- R1: `gateEn` bit `3*s+g` drives switch s+1 (s = 0..3), segment g (0 = first quarter, 1 = second quarter, 2 = half). In 2:1 mode (`modeDivide` = 1), a running charge cycle has four parts. It starts with PHASE_CLKS clocks of phase A, with switches 1 and 3 on. It continues with DEAD_CLKS clocks with everything off, then PHASE_CLKS clocks of phase B, with switches 2 and 4 on. It ends with DEAD_CLKS clocks with everything off. Phase A begins on the first clock of running.
- R2: In 2:1 mode, switches 1 and 3 are never on in the same clock as switches 2 and 4. Neither group turns on in the clock right after the other group was on.
- R3: In 1:1 mode (`modeDivide` = 0) while running, switch 3 stays off and switch 4 stays on. Switch 1 follows phase A and switch 2 follows phase B.
- R4: When `upperHit` is high at a clock edge while running, every gate is off from that edge on. Gates stay off until an edge at which `lowerHit` is high and `upperHit` is low. `upperHit` wins when both are high.
- R5: Running restarts with only segment 0 of each active switch. When three charge cycles have completed at that level, segment 1 is added as well.
- R6: When seven more charge cycles have completed at the two-quarter level, all three segments are used until the next skip.
- R7: While `softStart` is high and the block is running, all three segments of every active switch are on.
- R8: While `enN` is high or `fault` is high, all gates are off in that same clock. The controller returns to its reset state. Once it is released, it waits in skip for `lowerHit`.
- R9: `modeDivide` takes effect only in skip, or at the edge that ends a charge cycle. A change in the middle of a cycle leaves the current cycle's pattern unchanged.
- R10: Entering skip clears the charge-cycle count and the segment level. The next run starts from segment 0 alone, whatever level was reached before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enN | input | 1 | Active-low enable |
| fault | input | 1 | Undervoltage or over-temperature shutdown request |
| modeDivide | input | 1 | Mode comparator: 1 selects 2:1, 0 selects 1:1 |
| upperHit | input | 1 | Output at or above upper regulation limit |
| lowerHit | input | 1 | Output at or below lower regulation limit |
| softStart | input | 1 | Soft-start ramp active |
| gateEn | output | 12 | Per-segment gate enables, bit 3*s+g |

## Verification
A long stretch with both limit comparators quiet makes the level climb through quarter, half and full. This separates a correct escalation count from one that is off by a cycle. Random limit hits of varying spacing test whether skips are immediate and whether the count restarts. Mode flips placed in the middle of a phase separate latching at cycle boundaries from following the input freely. Pulses on soft-start, enable and fault check the overrides against the normal segment level.

// File: rtl/cpsc_pkg.sv
package cpsc_pkg;
  localparam int NUM_SW  = 4;
  localparam int NUM_SEG = 3;

  typedef enum logic [1:0] {
    LVL_QTR  = 2'd1,
    LVL_HALF = 2'd2,
    LVL_FULL = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SKIP = 2'd1,
    ST_RUN  = 2'd2
  } st_e;

  typedef struct packed {
    logic run;
    lvl_e level;
    logic divide;
  } strb_t;
endpackage

// File: rtl/cpsc_ctrl.sv
module cpsc_ctrl
  import cpsc_pkg::*;
#(
  parameter int HALF_AFTER = 3,
  parameter int FULL_AFTER = 7
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  enN,
  input  logic  fault,
  input  logic  modeDivide,
  input  logic  upperHit,
  input  logic  lowerHit,
  input  logic  softStart,
  input  logic  cycleEnd,
  output strb_t strb
);
  localparam int CNT_MAX = (HALF_AFTER > FULL_AFTER) ? HALF_AFTER : FULL_AFTER;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  st_e              state;
  lvl_e             level;
  logic [CNT_W-1:0] cycCnt;
  logic             modeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      level   <= LVL_QTR;
      cycCnt  <= '0;
      modeReg <= 1'b1;
    end else if (enN || fault) begin
      state   <= ST_OFF;
      level   <= LVL_QTR;
      cycCnt  <= '0;
      modeReg <= modeDivide;
    end else begin
      case (state)
        ST_OFF: begin
          modeReg <= modeDivide;
          state   <= ST_SKIP;
        end
        ST_SKIP: begin
          modeReg <= modeDivide;
          if (lowerHit && !upperHit) begin
            state  <= ST_RUN;
            level  <= LVL_QTR;
            cycCnt <= '0;
          end
        end
        ST_RUN: begin
          if (upperHit) begin
            state  <= ST_SKIP;
            level  <= LVL_QTR;
            cycCnt <= '0;
          end else if (cycleEnd) begin
            modeReg <= modeDivide;
            if (level == LVL_QTR && cycCnt == CNT_W'(HALF_AFTER - 1)) begin
              level  <= LVL_HALF;
              cycCnt <= '0;
            end else if (level == LVL_HALF && cycCnt == CNT_W'(FULL_AFTER - 1)) begin
              level  <= LVL_FULL;
              cycCnt <= '0;
            end else if (level != LVL_FULL) begin
              cycCnt <= cycCnt + 1'b1;
            end
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  always_comb begin
    strb.run    = (state == ST_RUN);
    strb.level  = softStart ? LVL_FULL : level;
    strb.divide = modeReg;
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && state == ST_RUN && $past(state) == ST_RUN && !$past(cycleEnd))
      |-> modeReg == $past(modeReg)); // R9
  AST_SHUTDOWN_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(enN || fault)) |-> state == ST_OFF); // R8
  AST_LEVEL_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && state == ST_RUN && $past(state) == ST_RUN) |-> level >= $past(level)); // R5
endmodule

// File: rtl/cpsc_phase_gen.sv
module cpsc_phase_gen
  import cpsc_pkg::*;
#(
  parameter int PHASE_CLKS = 4,
  parameter int DEAD_CLKS  = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strb_t                     strb,
  output logic                      cycleEnd,
  output logic [NUM_SW*NUM_SEG-1:0] gateRaw
);
  localparam int PERIOD = 2 * (PHASE_CLKS + DEAD_CLKS);
  localparam int POS_W  = $clog2(PERIOD);
  localparam int B_LO   = PHASE_CLKS + DEAD_CLKS;
  localparam int B_HI   = 2 * PHASE_CLKS + DEAD_CLKS;

  logic [POS_W-1:0]   pos;
  logic               phA, phB;
  logic [NUM_SEG-1:0] segMask;
  logic [NUM_SW-1:0]  swOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              pos <= '0;
    else if (!strb.run)                     pos <= '0;
    else if (pos == POS_W'(PERIOD - 1))     pos <= '0;
    else                                    pos <= pos + 1'b1;
  end

  assign cycleEnd = strb.run && (pos == POS_W'(PERIOD - 1));
  assign phA      = strb.run && (pos < POS_W'(PHASE_CLKS));
  assign phB      = strb.run && (pos >= POS_W'(B_LO)) && (pos < POS_W'(B_HI));

  always_comb begin
    segMask[0] = 1'b1;
    segMask[1] = (strb.level == LVL_HALF) || (strb.level == LVL_FULL);
    segMask[2] = (strb.level == LVL_FULL);
  end

  for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
    if (s == 0) begin : g_s1
      assign swOn[s] = phA;
    end else if (s == 1) begin : g_s2
      assign swOn[s] = phB;
    end else if (s == 2) begin : g_s3
      assign swOn[s] = phA && strb.divide;
    end else begin : g_s4
      assign swOn[s] = strb.divide ? phB : strb.run;
    end
    assign gateRaw[s*NUM_SEG +: NUM_SEG] = swOn[s] ? segMask : '0;
  end

  logic grpA, grpB;
  assign grpA = |{gateRaw[0 +: NUM_SEG], gateRaw[2*NUM_SEG +: NUM_SEG]};
  assign grpB = |{gateRaw[NUM_SEG +: NUM_SEG], gateRaw[3*NUM_SEG +: NUM_SEG]};

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.divide |-> !(grpA && grpB)); // R2
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && strb.divide && $past(strb.divide) && $past(grpA)) |-> !grpB); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.divide) |->
      (gateRaw[2*NUM_SEG +: NUM_SEG] == '0 && gateRaw[3*NUM_SEG] &&
       !(gateRaw[0] && gateRaw[NUM_SEG]))); // R3
endmodule

// File: rtl/cp_seg_ctrl.sv
module cp_seg_ctrl
  import cpsc_pkg::*;
#(
  parameter int PHASE_CLKS = 4,
  parameter int DEAD_CLKS  = 1,
  parameter int HALF_AFTER = 3,
  parameter int FULL_AFTER = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enN,
  input  logic        fault,
  input  logic        modeDivide,
  input  logic        upperHit,
  input  logic        lowerHit,
  input  logic        softStart,
  output logic [11:0] gateEn
);
  strb_t                     strb;
  logic                      cycleEnd;
  logic [NUM_SW*NUM_SEG-1:0] gateRaw;

  cpsc_ctrl #(.HALF_AFTER(HALF_AFTER), .FULL_AFTER(FULL_AFTER)) i_ctrl (
    .clk(clk), .rstN(rstN), .enN(enN), .fault(fault), .modeDivide(modeDivide),
    .upperHit(upperHit), .lowerHit(lowerHit), .softStart(softStart),
    .cycleEnd(cycleEnd), .strb(strb)
  );

  cpsc_phase_gen #(.PHASE_CLKS(PHASE_CLKS), .DEAD_CLKS(DEAD_CLKS)) i_phase (
    .clk(clk), .rstN(rstN), .strb(strb), .cycleEnd(cycleEnd), .gateRaw(gateRaw)
  );

  assign gateEn = gateRaw & {(NUM_SW*NUM_SEG){~(enN | fault)}};

  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(upperHit)) |-> gateEn == '0); // R4
endmodule

// File: tb/test_cp_seg_ctrl.sv
`timescale 1ns/1ps
module test_cp_seg_ctrl;
  localparam int PL = 4, DL = 1, HA = 3, FA = 7;
  localparam int PER = 2 * (PL + DL);

  logic clk = 0, rstN = 0, enN = 1, fault = 0, modeDivide = 1;
  logic upperHit = 0, lowerHit = 0, softStart = 0;
  logic [11:0] gateEn;

  int nVec = 0, nBad = 0;
  int mSt = 0, mPos = 0, mLvl = 1, mCnt = 0, mMode = 1;

  always #2.5 clk = ~clk;

  cp_seg_ctrl #(.PHASE_CLKS(PL), .DEAD_CLKS(DL), .HALF_AFTER(HA), .FULL_AFTER(FA))
    i_cp_seg_ctrl (.clk(clk), .rstN(rstN), .enN(enN), .fault(fault),
                   .modeDivide(modeDivide), .upperHit(upperHit), .lowerHit(lowerHit),
                   .softStart(softStart), .gateEn(gateEn));

  function automatic logic [11:0] expGates();
    logic [11:0] g = '0;
    logic [2:0] m;
    logic a, b;
    int el;
    if (!rstN || enN || fault || mSt != 2) return '0;
    el = softStart ? 3 : mLvl;
    m = {el == 3, el >= 2, 1'b1};
    a = mPos < PL;
    b = (mPos >= PL + DL) && (mPos < 2 * PL + DL);
    if (a) g[2:0] = m;
    if (b) g[5:3] = m;
    if (mMode == 1) begin
      if (a) g[8:6] = m;
      if (b) g[11:9] = m;
    end else begin
      g[11:9] = m;
    end
    return g;
  endfunction

  function automatic string autoTag();
    if (!rstN || enN || fault || mSt == 0) return "R8";
    if (mSt == 1) return "R4";
    if (softStart) return "R7";
    if (mMode == 0) return "R3";
    if (!(mPos < PL) && !(mPos >= PL + DL && mPos < 2 * PL + DL)) return "R2";
    if (mLvl == 3) return "R6";
    if (mLvl == 2) return "R5";
    return "R1";
  endfunction

  task automatic modelEdge();
    int nPos, nSt, nLvl, nCnt, nMode;
    logic cyc;
    cyc = (mSt == 2) && (mPos == PER - 1);
    nPos = (mSt != 2 || cyc) ? 0 : mPos + 1;
    nSt = mSt; nLvl = mLvl; nCnt = mCnt; nMode = mMode;
    if (!rstN) begin
      nSt = 0; nLvl = 1; nCnt = 0; nMode = 1; nPos = 0;
    end else if (enN || fault) begin
      nSt = 0; nLvl = 1; nCnt = 0; nMode = modeDivide;
    end else if (mSt == 0) begin
      nMode = modeDivide; nSt = 1;
    end else if (mSt == 1) begin
      nMode = modeDivide;
      if (lowerHit && !upperHit) begin nSt = 2; nLvl = 1; nCnt = 0; end
    end else if (upperHit) begin
      nSt = 1; nLvl = 1; nCnt = 0;
    end else if (cyc) begin
      nMode = modeDivide;
      if (mLvl == 1 && mCnt == HA - 1) begin nLvl = 2; nCnt = 0; end
      else if (mLvl == 2 && mCnt == FA - 1) begin nLvl = 3; nCnt = 0; end
      else if (mLvl != 3) nCnt = mCnt + 1;
    end
    mSt = nSt; mPos = nPos; mLvl = nLvl; mCnt = nCnt; mMode = nMode;
  endtask

  task automatic step(input string tagOv);
    logic [11:0] e;
    string t;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    e = expGates();
    t = (tagOv == "") ? autoTag() : tagOv;
    nVec++;
    if (gateEn !== e) begin
      nBad++;
      $display("FAIL %s t=%0t gateEn actual=%03h expected=%03h", t, $time, gateEn, e);
    end
  endtask

  initial begin
    #750000;
    nBad++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) step("R8");
    @(negedge clk); rstN = 1;
    step("R8");
    // enable, then start and let the level climb (R5, R6)
    enN = 0; step("R8");
    lowerHit = 1; step("R4");
    lowerHit = 0;
    for (int i = 0; i < PER * (HA + FA + 3); i++) step("");
    // skip from full, resume at quarter (R10)
    upperHit = 1; step("R4");
    upperHit = 1; lowerHit = 1; step("R4");
    upperHit = 0; step("R10");
    lowerHit = 0;
    repeat (PER * 2) step("R10");
    // mode flip mid-cycle must wait for boundary (R9)
    step("R9");
    modeDivide = 0;
    repeat (PER) step("R9");
    repeat (PER * 2) step("R3");
    modeDivide = 1;
    repeat (PER + 2) step("R9");
    // soft start override (R7)
    softStart = 1; repeat (PER) step("R7");
    softStart = 0;
    // fault and disable (R8)
    fault = 1; repeat (3) step("R8");
    fault = 0; step("R8"); step("R8");
    lowerHit = 1; step("R4"); lowerHit = 0;
    repeat (PER) step("");
    enN = 1; step("R8"); enN = 0; step("R8");
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      upperHit   = ($urandom % 24) == 0;
      lowerHit   = ($urandom % 5) == 0;
      if (($urandom % 40) == 0) modeDivide = ~modeDivide;
      if (($urandom % 90) == 0) softStart = ~softStart;
      fault      = ($urandom % 400) == 0;
      if (($urandom % 700) == 0) enN = 1; else if (enN && ($urandom % 4) == 0) enN = 0;
      step("");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule